// File: doc/BRIEF.md
# Reset Sequencer with Vector Selection

This block produces the chip-wide reset sequence and decides which reset vector the processor fetches afterwards. Five request sources feed it: a power-on detector, an illegal-address detector, a watchdog timeout, an oscillator-failure monitor and the bidirectional active-low reset pad. Any of them forces the internal reset and the pad pull-down on at once, with no clock edge needed. Leaving reset is paced by the clock. The request is first synchronized off, then the pad is pulled low for `DRIVE_CYC` cycles. The pad is then released, and after a further `WAIT_CYC` cycles its level is sampled.

If the sampled pad is high, the vector comes from the pending flags: a latched oscillator failure wins over a latched watchdog timeout, and with neither flag set the cold-start vector is used. If the sampled pad is low, something outside is still holding the pad. The cold-start vector is then chosen whatever the flags say, and the internal reset stays on until the pad goes high. A new request at any point in the sequence starts the drive phase again from zero. Control and status pins are plain levels; the block has no streaming interface.

Top module: `rst_sequencer`

## Requirements
- R1: Any request raises `sys_rst_o` and `pin_drive_o` without waiting for a clock edge; while `por_i` is held, `sys_rst_o`=1, `pin_drive_o`=1 and `vec_valid_o`=0.
- R2: After the last request is withdrawn, `pin_drive_o` stays high for at least `DRIVE_CYC` and at most `DRIVE_CYC`+4 clock cycles.
- R3: Once `pin_drive_o` falls with the pad free, `sys_rst_o` stays high for `WAIT_CYC` to `WAIT_CYC`+3 further cycles and then falls; `pin_drive_o` never rises while `sys_rst_o` is low.
- R4: If the pad is still held low from outside when the wait ends, `sys_rst_o` stays high until the pad rises, then falls within 5 cycles with `vec_sel_o`=2'b00, whatever flags are pending.
- R5: With the pad sampled high and an oscillator failure latched, `vec_sel_o`=2'b01, even if a watchdog timeout is also latched.
- R6: With the pad sampled high, a watchdog timeout latched and no oscillator failure latched, `vec_sel_o`=2'b10; with neither latched, `vec_sel_o`=2'b00.
- R7: Pending flags are cleared when internal reset is released, so a later sequence without new flags yields 2'b00.
- R8: A request arriving during the drive or wait phase re-asserts `pin_drive_o` at once and restarts the drive phase from zero.
- R9: `vec_valid_o` is high exactly while `sys_rst_o` is low; while it is high, `vec_sel_o` is never 2'b11 and does not change.
- R10: The pad pulled low from outside while the chip is running starts a reset sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencing clock |
| por_i | input | 1 | Power-on detected, active high |
| illegal_i | input | 1 | Illegal address access detected |
| wdog_i | input | 1 | Watchdog timeout |
| oscfail_i | input | 1 | Oscillator monitor failure |
| pin_in_i | input | 1 | Level read back from the reset pad, low = reset |
| pin_drive_o | output | 1 | Enables the open-drain pull-down of the reset pad |
| sys_rst_o | output | 1 | Internal reset to the rest of the chip |
| vec_valid_o | output | 1 | The vector select is valid (internal reset released) |
| vec_sel_o | output | 2 | 00 cold/external/illegal, 01 oscillator fail, 10 watchdog |

## Verification
The properties are switched off while `por_i` is high, so they assume that power-on is asserted first and that the clock runs once it is removed. They also assume the pad reads low whenever `pin_drive_o` is set, and that requests change only between clock edges. The bench models the pad as the AND of the block's pull-down and an external holder. It raises every request in the middle of the low clock phase and drops it before the next rising edge, or holds it whole cycles. It releases the external holder only on falling edges, so the pad never changes at a sampling edge.

// File: rtl/rsq_pkg.sv
`timescale 1ns/1ps
package rsq_pkg;
  typedef enum logic [1:0] {
    ST_DRIVE = 2'd0,
    ST_WAIT  = 2'd1,
    ST_HOLD  = 2'd2,
    ST_RUN   = 2'd3
  } rsq_state_e;

  typedef enum logic [1:0] {
    VEC_COLD    = 2'b00,
    VEC_CLKFAIL = 2'b01,
    VEC_WDOG    = 2'b10
  } rsq_vec_e;

  localparam int unsigned FLAG_N   = 2;
  localparam int unsigned FLAG_OSC = 0;
  localparam int unsigned FLAG_WD  = 1;
endpackage

// File: rtl/rsq_capture.sv
`timescale 1ns/1ps
// Captures any request asynchronously and releases it through a
// synchronizer chain, so the hold output rises at once but falls on a clock.
module rsq_capture #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic evt_i,
  output logic hold_o
);
  logic              req_q;
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or posedge evt_i) begin
    if (evt_i) req_q <= 1'b1;
    else       req_q <= 1'b0;
  end

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or posedge req_q) begin
        if (req_q) chain_q <= '1;
        else       chain_q <= '0;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or posedge req_q) begin
        if (req_q) chain_q <= '1;
        else       chain_q <= {chain_q[STAGES-2:0], 1'b0};
      end
    end
  endgenerate

  assign hold_o = chain_q[STAGES-1];
endmodule

// File: rtl/rsq_flag.sv
`timescale 1ns/1ps
// Pending flag: set without a clock, cleared on a clock edge.
module rsq_flag (
  input  logic clk_i,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk_i or posedge set_i) begin
    if (set_i)      pend_o <= 1'b1;
    else if (clr_i) pend_o <= 1'b0;
  end
endmodule

// File: rtl/rsq_sync.sv
`timescale 1ns/1ps
// Plain multi-stage synchronizer for the pad read-back.
module rsq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i) sh_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i) sh_q <= {sh_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/rsq_fsm.sv
`timescale 1ns/1ps
// Drive / wait / hold sequencer with vector decision.
module rsq_fsm
  import rsq_pkg::*;
#(
  parameter int unsigned DRIVE_CYC = 516,
  parameter int unsigned WAIT_CYC  = 256
) (
  input  logic       clk_i,
  input  logic       hold_i,
  input  logic       pin_s_i,
  input  logic       osc_pend_i,
  input  logic       wd_pend_i,
  output rsq_state_e state_o,
  output logic [1:0] vec_o,
  output logic       release_o
);
  localparam int unsigned SPAN  = (DRIVE_CYC > WAIT_CYC) ? DRIVE_CYC : WAIT_CYC;
  localparam int unsigned CNT_W = $clog2(SPAN) + 1;
  localparam logic [CNT_W-1:0] DRV_LAST  = CNT_W'(DRIVE_CYC - 1);
  localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_CYC - 1);

  rsq_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  rsq_vec_e         vec_q;
  rsq_vec_e         pick;
  logic             wait_done;

  always_comb begin
    if (osc_pend_i)     pick = VEC_CLKFAIL;
    else if (wd_pend_i) pick = VEC_WDOG;
    else                pick = VEC_COLD;
  end

  assign wait_done = (st_q == ST_WAIT) && (cnt_q == WAIT_LAST);

  always_ff @(posedge clk_i) begin
    if (hold_i) begin
      st_q  <= ST_DRIVE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_DRIVE: begin
          if (cnt_q == DRV_LAST) begin
            st_q  <= ST_WAIT;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_WAIT: begin
          if (wait_done) begin
            cnt_q <= '0;
            if (pin_s_i) begin
              st_q  <= ST_RUN;
              vec_q <= pick;
            end else begin
              st_q  <= ST_HOLD;
              vec_q <= VEC_COLD;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_HOLD: begin
          if (pin_s_i) st_q <= ST_RUN;
        end
        default: begin
          st_q <= ST_RUN;
        end
      endcase
    end
  end

  assign release_o = !hold_i && pin_s_i && (wait_done || (st_q == ST_HOLD));
  assign state_o   = st_q;
  assign vec_o     = vec_q;
endmodule

// File: rtl/rst_sequencer.sv
`timescale 1ns/1ps
// Top: request capture, pending flags, pad synchronizer and sequencer.
module rst_sequencer
  import rsq_pkg::*;
#(
  parameter int unsigned DRIVE_CYC   = 516,
  parameter int unsigned WAIT_CYC    = 256,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       por_i,
  input  logic       illegal_i,
  input  logic       wdog_i,
  input  logic       oscfail_i,
  input  logic       pin_in_i,
  output logic       pin_drive_o,
  output logic       sys_rst_o,
  output logic       vec_valid_o,
  output logic [1:0] vec_sel_o
);
  rsq_state_e        state;
  logic              running;
  logic              evt;
  logic              hold;
  logic              pin_s;
  logic              rel;
  logic              flag_clr;
  logic [FLAG_N-1:0] flag_set;
  logic [FLAG_N-1:0] flag_pend;
  logic [1:0]        vec;

  assign running = (state == ST_RUN);
  // The pad counts as a request only while the chip is running.
  assign evt = por_i | illegal_i | wdog_i | oscfail_i | (running & ~pin_in_i);

  rsq_capture #(.STAGES(SYNC_STAGES)) u_capture (
    .clk_i  (clk_i),
    .evt_i  (evt),
    .hold_o (hold)
  );

  rsq_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk_i (clk_i),
    .d_i   (pin_in_i),
    .q_o   (pin_s)
  );

  assign flag_set[FLAG_OSC] = oscfail_i;
  assign flag_set[FLAG_WD]  = wdog_i;
  assign flag_clr           = rel | por_i;

  for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
    rsq_flag u_flag (
      .clk_i  (clk_i),
      .set_i  (flag_set[g]),
      .clr_i  (flag_clr),
      .pend_o (flag_pend[g])
    );
  end

  rsq_fsm #(
    .DRIVE_CYC (DRIVE_CYC),
    .WAIT_CYC  (WAIT_CYC)
  ) u_fsm (
    .clk_i      (clk_i),
    .hold_i     (hold),
    .pin_s_i    (pin_s),
    .osc_pend_i (flag_pend[FLAG_OSC]),
    .wd_pend_i  (flag_pend[FLAG_WD]),
    .state_o    (state),
    .vec_o      (vec),
    .release_o  (rel)
  );

  assign pin_drive_o = hold | (state == ST_DRIVE);
  assign sys_rst_o   = hold | ~running;
  assign vec_valid_o = ~sys_rst_o;
  assign vec_sel_o   = vec;
endmodule

// File: rtl/rsq_checker.sv
`timescale 1ns/1ps
module rsq_checker #(
  parameter int unsigned DRIVE_CYC = 516
) (
  input logic       clk_i,
  input logic       por_i,
  input logic       illegal_i,
  input logic       wdog_i,
  input logic       oscfail_i,
  input logic       pin_in_i,
  input logic       pin_drive_o,
  input logic       sys_rst_o,
  input logic       vec_valid_o,
  input logic [1:0] vec_sel_o
);
  localparam int unsigned CW = $clog2(DRIVE_CYC + 1) + 2;
  localparam logic [CW-1:0] LIM = CW'(DRIVE_CYC);
  logic [CW-1:0] low_run;

  // Length of the current pull-down stretch, saturating.
  always_ff @(posedge clk_i) begin
    if (por_i || !pin_drive_o) low_run <= '0;
    else if (low_run != '1)    low_run <= low_run + 1'b1;
  end

  AST_ENTRY_RST: assert property (@(posedge clk_i) disable iff (por_i)
    (illegal_i | wdog_i | oscfail_i) |-> (sys_rst_o && pin_drive_o)); // R1
  AST_DRIVE_MIN: assert property (@(posedge clk_i) disable iff (por_i)
    $fell(pin_drive_o) |-> (low_run >= LIM)); // R2
  AST_DRIVE_IN_RST: assert property (@(posedge clk_i) disable iff (por_i)
    pin_drive_o |-> sys_rst_o); // R3
  AST_RELEASE_PAD_HIGH: assert property (@(posedge clk_i) disable iff (por_i)
    $fell(sys_rst_o) |-> pin_in_i); // R4
  AST_VEC_CODE: assert property (@(posedge clk_i) disable iff (por_i)
    vec_valid_o |-> (vec_sel_o != 2'b11)); // R9
  AST_VEC_STABLE: assert property (@(posedge clk_i) disable iff (por_i)
    (vec_valid_o && $past(vec_valid_o)) |-> $stable(vec_sel_o)); // R9
  AST_VALID_NO_DRIVE: assert property (@(posedge clk_i) disable iff (por_i)
    vec_valid_o |-> !pin_drive_o); // R9
endmodule

bind rst_sequencer rsq_checker #(.DRIVE_CYC(DRIVE_CYC)) u_chk (
  .clk_i       (clk_i),
  .por_i       (por_i),
  .illegal_i   (illegal_i),
  .wdog_i      (wdog_i),
  .oscfail_i   (oscfail_i),
  .pin_in_i    (pin_in_i),
  .pin_drive_o (pin_drive_o),
  .sys_rst_o   (sys_rst_o),
  .vec_valid_o (vec_valid_o),
  .vec_sel_o   (vec_sel_o)
);

// File: tb/rst_sequencer_tb.sv
`timescale 1ns/1ps
module rst_sequencer_tb;
  localparam int DRV = 516;
  localparam int WT  = 256;
  localparam int LIMIT = 5000;

  logic clk = 1'b0;
  logic por = 1'b1;
  logic ill = 1'b0;
  logic wd  = 1'b0;
  logic osc = 1'b0;
  logic ext_low = 1'b0;
  logic pin_in;
  logic pin_drive, sys_rst, vvalid;
  logic [1:0] vsel;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  assign pin_in = ~(pin_drive | ext_low);

  rst_sequencer #(.DRIVE_CYC(DRV), .WAIT_CYC(WT)) u_dut (
    .clk_i(clk), .por_i(por), .illegal_i(ill), .wdog_i(wd), .oscfail_i(osc),
    .pin_in_i(pin_in), .pin_drive_o(pin_drive), .sys_rst_o(sys_rst),
    .vec_valid_o(vvalid), .vec_sel_o(vsel));

  // Fields: [7:5] source (0 por,1 illegal,2 watchdog,3 osc,4 pad),
  // [4] extra osc, [3] extra watchdog, [2] pad held past wait, [1:0] expected vector.
  localparam logic [7:0] TBL [8] = '{
    {3'd2, 1'b0, 1'b0, 1'b0, 2'b10},
    {3'd0, 1'b0, 1'b0, 1'b0, 2'b00},
    {3'd3, 1'b0, 1'b0, 1'b0, 2'b01},
    {3'd3, 1'b0, 1'b1, 1'b0, 2'b01},
    {3'd1, 1'b0, 1'b1, 1'b0, 2'b10},
    {3'd4, 1'b0, 1'b0, 1'b0, 2'b00},
    {3'd2, 1'b0, 1'b0, 1'b1, 2'b00},
    {3'd3, 1'b0, 1'b1, 1'b1, 2'b00}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input int src, input bit xo, input bit xw);
    ill = (src == 1); wd = (src == 2) | xw; osc = (src == 3) | xo; por = (src == 0);
  endtask

  task automatic clear_pulse();
    ill = 1'b0; wd = 1'b0; osc = 1'b0; por = 1'b0;
  endtask

  task automatic count_drive(output int n);
    n = 0;
    while (pin_drive && n < LIMIT) begin n++; @(negedge clk); end
  endtask

  task automatic count_rst(output int n);
    n = 0;
    while (sys_rst && n < LIMIT) begin n++; @(negedge clk); end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    int n;
    int m;
    // Reset state under power-on (R1)
    repeat (10) @(negedge clk);
    check(sys_rst == 1 && pin_drive == 1 && vvalid == 0, "R1 por state",
          {sys_rst, pin_drive, vvalid}, 3'b110);
    por = 1'b0;
    count_drive(n);
    check(n >= DRV && n <= DRV + 4, "R2 drive after por", n, DRV);
    count_rst(n);
    check(n >= WT && n <= WT + 3, "R3 wait after por", n, WT);
    check(vvalid == 1 && vsel == 2'b00, "R6 cold vector", vsel, 0);

    // Table walk
    foreach (TBL[i]) begin
      automatic int src = int'(TBL[i][7:5]);
      automatic bit xo = TBL[i][4];
      automatic bit xw = TBL[i][3];
      automatic bit hold = TBL[i][2];
      automatic logic [1:0] exp = TBL[i][1:0];
      repeat (5) @(negedge clk);
      #1;
      if (src == 4 || hold) ext_low = 1'b1;
      pulse(src, xo, xw);
      #1;
      check(sys_rst == 1 && pin_drive == 1, "R1 async entry", {sys_rst, pin_drive}, 2'b11);
      #1;
      clear_pulse();
      @(negedge clk);
      n = 0;
      if (src == 4 && !hold) begin
        repeat (3) @(negedge clk);
        ext_low = 1'b0;
        n = 3;
      end
      count_drive(m);
      n += m;
      check(n >= DRV && n <= DRV + 5, "R2 drive length", n, DRV);
      if (hold) begin
        repeat (WT + 20) @(negedge clk);
        check(sys_rst == 1 && vvalid == 0, "R4 extended by pad", sys_rst, 1);
        ext_low = 1'b0;
        count_rst(n);
        check(n <= 5, "R4 release after pad", n, 3);
      end else begin
        count_rst(n);
        check(n >= WT && n <= WT + 3, "R3 wait length", n, WT);
      end
      check(vvalid == 1 && vsel == exp, "R5 R6 R7 R10 vector", vsel, exp);
      repeat (20) @(negedge clk);
      check(vvalid == 1 && vsel == exp, "R9 vector held", vsel, exp);
    end

    // Restart inside drive phase (R8)
    repeat (5) @(negedge clk);
    #1 wd = 1'b1; #2 wd = 1'b0;
    repeat (300) @(negedge clk);
    #1 ill = 1'b1; #2 ill = 1'b0;
    @(negedge clk);
    count_drive(n);
    check(n >= DRV && n <= DRV + 4, "R8 restart in drive", n, DRV);
    count_rst(n);
    check(vsel == 2'b10 && vvalid == 1, "R8 vector after restart", vsel, 2);

    // Restart inside wait phase (R8)
    repeat (5) @(negedge clk);
    #1 osc = 1'b1; #2 osc = 1'b0;
    @(negedge clk);
    count_drive(n);
    repeat (100) @(negedge clk);
    check(pin_drive == 0 && sys_rst == 1, "R3 in wait", pin_drive, 0);
    #1 wd = 1'b1; #1;
    check(pin_drive == 1, "R8 pad re-driven", pin_drive, 1);
    #1 wd = 1'b0;
    @(negedge clk);
    count_drive(n);
    check(n >= DRV && n <= DRV + 4, "R8 restart in wait", n, DRV);
    count_rst(n);
    check(n >= WT && n <= WT + 3, "R3 wait after restart", n, WT);
    check(vsel == 2'b01 && vvalid == 1, "R5 osc kept over restart", vsel, 1);

    // Flags cleared: next plain power-on gives cold vector (R7)
    repeat (5) @(negedge clk);
    #1 por = 1'b1; #2 por = 1'b0;
    @(negedge clk);
    count_drive(n);
    count_rst(n);
    check(vsel == 2'b00 && vvalid == 1, "R7 flags cleared", vsel, 0);

    finish_up();
  end
endmodule